// File: doc/BRIEF.md
# Illegal Instruction Exception Sequencer

This block sits next to a processor's decode stage and watches each decoded instruction for two faults. The first is a slot fault. It is an undefined opcode, or any opcode that writes the program counter, found in the slot that follows a delayed branch. The second is a general fault, which is an undefined opcode found anywhere else. When the block sees either fault, it takes over and runs the exception entry sequence itself.

The sequence has four steps:
- Write the status word to the stack.
- Write a return address to the stack.
- Read the handler address from the vector table.
- Load that address into the fetch unit as a plain jump, so no slot instruction follows it.

A slot fault stacks the target of the delayed branch as its return address. A general fault stacks the address of the faulting opcode. The sequence holds the decode stage stalled through a busy flag. Every memory access waits on a ready handshake.

Top module: `illx_entry_seq`

## Requirements
- R1: A valid instruction that is undefined and sits in a delay slot starts the slot sequence. The stacked return address is `slot_target_i`, and the vector number is 6.
- R2: A valid instruction in a delay slot that writes the program counter starts the slot sequence, even if its opcode is defined.
- R3: A valid undefined instruction outside a delay slot starts the general sequence. The stacked return address is `dec_pc_i`, and the vector number is 4.
- R4: The following start no sequence: an invalid instruction, a defined instruction outside a slot, and a defined PC-writing instruction outside a slot. In each case busy stays low and no memory access is made.
- R5: The first write goes to address SP−4 and carries the status word, zero-extended. The second write goes to address SP−8 and carries the return address. SP is the value of `sp_i` sampled at detection.
- R6: The single read that follows the two writes fetches from address VBR + 4 × vector number. VBR is sampled at detection.
- R7: Each write or read holds its strobe, address and data steady until its ready input is high. With a ready latency of L cycles, busy stays high for exactly 3·(L+1)+1 cycles.
- R8: After the read, `pc_load_o` pulses for one cycle and carries the word that was read. In the same cycle, `sp_load_o` carries SP−8.
- R9: Busy rises in the cycle after detection and stays high through the `pc_load_o` cycle. Detection inputs are ignored while busy is high, and a detection in the first idle cycle after the load is accepted.
- R10: While reset is held, busy, both memory strobes and the load pulses are low.
- R11: At most one of the write strobe, the read strobe and the PC load is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage presents an instruction |
| dec_undef_i | input | 1 | The opcode is undefined |
| dec_pc_write_i | input | 1 | The instruction writes the program counter |
| dec_in_slot_i | input | 1 | The instruction sits in a delay slot |
| dec_pc_i | input | AW | Address of the decoded instruction |
| slot_target_i | input | AW | Target of the delayed branch before the slot |
| sr_i | input | SRW | Current status word |
| sp_i | input | AW | Current stack pointer |
| vbr_i | input | AW | Vector table base |
| busy_o | output | 1 | Stall request to decode |
| mem_wr_en_o | output | 1 | Stack write strobe |
| mem_wr_addr_o | output | AW | Stack write byte address |
| mem_wr_data_o | output | AW | Stack write data |
| mem_wr_ready_i | input | 1 | Write accepted |
| mem_rd_en_o | output | 1 | Vector read strobe |
| mem_rd_addr_o | output | AW | Vector read byte address |
| mem_rd_data_i | input | AW | Vector read data |
| mem_rd_ready_i | input | 1 | Read data valid |
| pc_load_o | output | 1 | Fetch redirect pulse |
| pc_new_o | output | AW | Handler address |
| sp_load_o | output | 1 | Stack pointer update pulse |
| sp_new_o | output | AW | Stack pointer after the two writes |

## Verification
Two events can land in the same cycle: a new detection, and the final handler load of the running sequence. The bench provokes this by holding an undefined opcode on decode without a break, so a fault is present on the very cycle of the load. It judges the result on three counts. Exactly two full sequences must appear. Busy must drop for exactly one cycle between them. The second sequence must stack the same context as the first. A separate test injects a slot fault midway through a running sequence and expects the first sequence's values to come out unchanged.

// File: rtl/illx_pkg.sv
package illx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_PUSH_SR   = 3'd1,
      ST_PUSH_PC   = 3'd2,
      ST_FETCH_VEC = 3'd3,
      ST_LOAD_PC   = 3'd4
   } illx_state_e;

   typedef enum logic [1:0] {
      EXC_NONE    = 2'd0,
      EXC_GENERAL = 2'd1,
      EXC_SLOT    = 2'd2
   } illx_kind_e;

   function automatic logic is_fault(input illx_kind_e k);
      return (k != EXC_NONE);
   endfunction

endpackage

// File: rtl/illx_classify.sv
module illx_classify
   import illx_pkg::*;
#(
   parameter int AW             = 32,
   parameter bit SLOT_PCW_FAULT = 1'b1
) (
   input  logic          valid_i,
   input  logic          undef_i,
   input  logic          pc_write_i,
   input  logic          in_slot_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] slot_target_i,
   output illx_kind_e    kind_o,
   output logic [AW-1:0] ret_pc_o
);

   logic slot_bad;

   generate
      if (SLOT_PCW_FAULT) begin : g_slot_pcw
         assign slot_bad = in_slot_i & (undef_i | pc_write_i);
      end else begin : g_slot_undef_only
         logic unused_pcw;
         assign unused_pcw = pc_write_i;
         assign slot_bad   = in_slot_i & undef_i;
      end
   endgenerate

   always_comb begin
      kind_o = EXC_NONE;
      if (valid_i) begin
         if (slot_bad)
            kind_o = EXC_SLOT;
         else if (undef_i && !in_slot_i)
            kind_o = EXC_GENERAL;
      end
   end

   always_comb begin
      ret_pc_o = (kind_o == EXC_SLOT) ? slot_target_i : pc_i;
   end

endmodule

// File: rtl/illx_ctx.sv
module illx_ctx
   import illx_pkg::*;
#(
   parameter int AW          = 32,
   parameter int SRW         = 32,
   parameter int VEC_W       = 8,
   parameter int VEC_GEN     = 4,
   parameter int VEC_SLOT    = 6,
   parameter bit CAPTURE_VBR = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           capture_i,
   input  illx_kind_e     kind_i,
   input  logic [AW-1:0]  ret_pc_i,
   input  logic [SRW-1:0] sr_i,
   input  logic [AW-1:0]  sp_i,
   input  logic [AW-1:0]  vbr_i,
   output logic [AW-1:0]  addr_sr_o,
   output logic [AW-1:0]  data_sr_o,
   output logic [AW-1:0]  addr_pc_o,
   output logic [AW-1:0]  data_pc_o,
   output logic [AW-1:0]  vec_addr_o,
   output logic [AW-1:0]  sp_final_o
);

   localparam int WORD_BYTES = AW / 8;
   localparam int VEC_SHIFT  = $clog2(WORD_BYTES);
   localparam logic [AW-1:0] STEP1 = AW'(WORD_BYTES);
   localparam logic [AW-1:0] STEP2 = AW'(2 * WORD_BYTES);

   logic [AW-1:0]    sr_ext;
   logic [AW-1:0]    sr_q;
   logic [AW-1:0]    ret_q;
   logic [AW-1:0]    sp_q;
   logic [VEC_W-1:0] vec_d;
   logic [VEC_W-1:0] vec_q;
   logic [AW-1:0]    vbr_sel;

   generate
      if (SRW < AW) begin : g_sr_pad
         assign sr_ext = {{(AW-SRW){1'b0}}, sr_i};
      end else begin : g_sr_full
         assign sr_ext = sr_i;
      end
   endgenerate

   always_comb begin
      vec_d = VEC_W'(VEC_GEN);
      if (kind_i == EXC_SLOT)
         vec_d = VEC_W'(VEC_SLOT);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q  <= '0;
         ret_q <= '0;
         sp_q  <= '0;
         vec_q <= '0;
      end else if (capture_i) begin
         sr_q  <= sr_ext;
         ret_q <= ret_pc_i;
         sp_q  <= sp_i;
         vec_q <= vec_d;
      end
   end

   generate
      if (CAPTURE_VBR) begin : g_vbr_reg
         logic [AW-1:0] vbr_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               vbr_q <= '0;
            else if (capture_i)
               vbr_q <= vbr_i;
         end
         assign vbr_sel = vbr_q;
      end else begin : g_vbr_live
         assign vbr_sel = vbr_i;
      end
   endgenerate

   assign addr_sr_o  = sp_q - STEP1;
   assign addr_pc_o  = sp_q - STEP2;
   assign sp_final_o = sp_q - STEP2;
   assign data_sr_o  = sr_q;
   assign data_pc_o  = ret_q;
   assign vec_addr_o = vbr_sel + (AW'(vec_q) << VEC_SHIFT);

   // R9
   ctx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !capture_i |=> $stable(ret_q) && $stable(sp_q) && $stable(vec_q));

   // R1
   slot_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (capture_i && kind_i == EXC_SLOT) |=> vec_q == VEC_W'(VEC_SLOT));

endmodule

// File: rtl/illx_fsm.sv
module illx_fsm
   import illx_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          detect_i,
   output logic          busy_o,
   output logic          capture_o,
   input  logic [AW-1:0] addr_sr_i,
   input  logic [AW-1:0] data_sr_i,
   input  logic [AW-1:0] addr_pc_i,
   input  logic [AW-1:0] data_pc_i,
   input  logic [AW-1:0] vec_addr_i,
   input  logic [AW-1:0] sp_final_i,
   output logic          mem_wr_en_o,
   output logic [AW-1:0] mem_wr_addr_o,
   output logic [AW-1:0] mem_wr_data_o,
   input  logic          mem_wr_ready_i,
   output logic          mem_rd_en_o,
   output logic [AW-1:0] mem_rd_addr_o,
   input  logic [AW-1:0] mem_rd_data_i,
   input  logic          mem_rd_ready_i,
   output logic          pc_load_o,
   output logic [AW-1:0] pc_new_o,
   output logic          sp_load_o,
   output logic [AW-1:0] sp_new_o
);

   illx_state_e   st_q, st_d;
   logic [AW-1:0] handler_q;

   assign capture_o = (st_q == ST_IDLE) && detect_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:      if (detect_i)       st_d = ST_PUSH_SR;
         ST_PUSH_SR:   if (mem_wr_ready_i) st_d = ST_PUSH_PC;
         ST_PUSH_PC:   if (mem_wr_ready_i) st_d = ST_FETCH_VEC;
         ST_FETCH_VEC: if (mem_rd_ready_i) st_d = ST_LOAD_PC;
         ST_LOAD_PC:                       st_d = ST_IDLE;
         default:                          st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         handler_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_FETCH_VEC && mem_rd_ready_i)
            handler_q <= mem_rd_data_i;
      end
   end

   always_comb begin
      mem_wr_en_o   = 1'b0;
      mem_wr_addr_o = '0;
      mem_wr_data_o = '0;
      mem_rd_en_o   = 1'b0;
      mem_rd_addr_o = '0;
      pc_load_o     = 1'b0;
      pc_new_o      = '0;
      sp_load_o     = 1'b0;
      sp_new_o      = '0;
      unique case (st_q)
         ST_PUSH_SR: begin
            mem_wr_en_o   = 1'b1;
            mem_wr_addr_o = addr_sr_i;
            mem_wr_data_o = data_sr_i;
         end
         ST_PUSH_PC: begin
            mem_wr_en_o   = 1'b1;
            mem_wr_addr_o = addr_pc_i;
            mem_wr_data_o = data_pc_i;
         end
         ST_FETCH_VEC: begin
            mem_rd_en_o   = 1'b1;
            mem_rd_addr_o = vec_addr_i;
         end
         ST_LOAD_PC: begin
            pc_load_o = 1'b1;
            pc_new_o  = handler_q;
            sp_load_o = 1'b1;
            sp_new_o  = sp_final_i;
         end
         default: ;
      endcase
   end

   assign busy_o = (st_q != ST_IDLE);

   // R7
   wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_wr_en_o && !mem_wr_ready_i) |=>
         mem_wr_en_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));

   // R7
   rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_rd_en_o && !mem_rd_ready_i) |=> mem_rd_en_o && $stable(mem_rd_addr_o));

   // R11
   one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({mem_wr_en_o, mem_rd_en_o, pc_load_o}));

   // R8
   pc_load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc_load_o |=> !pc_load_o);

   // R5
   sr_before_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_wr_en_o && mem_wr_ready_i && mem_wr_addr_o == addr_sr_i) |=>
         mem_wr_en_o && mem_wr_addr_o == addr_pc_i);

   // R9
   load_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc_load_o |-> busy_o);

endmodule

// File: rtl/illx_entry_seq.sv
module illx_entry_seq
   import illx_pkg::*;
#(
   parameter int AW             = 32,
   parameter int SRW            = 32,
   parameter int VEC_W          = 8,
   parameter int VEC_GEN        = 4,
   parameter int VEC_SLOT       = 6,
   parameter bit CAPTURE_VBR    = 1'b1,
   parameter bit SLOT_PCW_FAULT = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           dec_valid_i,
   input  logic           dec_undef_i,
   input  logic           dec_pc_write_i,
   input  logic           dec_in_slot_i,
   input  logic [AW-1:0]  dec_pc_i,
   input  logic [AW-1:0]  slot_target_i,
   input  logic [SRW-1:0] sr_i,
   input  logic [AW-1:0]  sp_i,
   input  logic [AW-1:0]  vbr_i,
   output logic           busy_o,
   output logic           mem_wr_en_o,
   output logic [AW-1:0]  mem_wr_addr_o,
   output logic [AW-1:0]  mem_wr_data_o,
   input  logic           mem_wr_ready_i,
   output logic           mem_rd_en_o,
   output logic [AW-1:0]  mem_rd_addr_o,
   input  logic [AW-1:0]  mem_rd_data_i,
   input  logic           mem_rd_ready_i,
   output logic           pc_load_o,
   output logic [AW-1:0]  pc_new_o,
   output logic           sp_load_o,
   output logic [AW-1:0]  sp_new_o
);

   generate
      if (AW < 16 || (AW % 8) != 0) begin : g_bad_aw
         $error("illx_entry_seq: AW must be a byte multiple of at least 16");
      end
      if (SRW < 1 || SRW > AW) begin : g_bad_srw
         $error("illx_entry_seq: SRW must lie in 1..AW");
      end
      if (VEC_GEN == VEC_SLOT) begin : g_bad_vec
         $error("illx_entry_seq: the two vector numbers must differ");
      end
      if (VEC_GEN >= (1 << VEC_W) || VEC_SLOT >= (1 << VEC_W)) begin : g_bad_vw
         $error("illx_entry_seq: vector number exceeds VEC_W");
      end
   endgenerate

   illx_kind_e    kind;
   logic [AW-1:0] ret_pc;
   logic          detect;
   logic          capture;
   logic [AW-1:0] addr_sr, data_sr, addr_pc, data_pc, vec_addr, sp_final;

   illx_classify #(
      .AW             (AW),
      .SLOT_PCW_FAULT (SLOT_PCW_FAULT)
   ) u_classify (
      .valid_i       (dec_valid_i),
      .undef_i       (dec_undef_i),
      .pc_write_i    (dec_pc_write_i),
      .in_slot_i     (dec_in_slot_i),
      .pc_i          (dec_pc_i),
      .slot_target_i (slot_target_i),
      .kind_o        (kind),
      .ret_pc_o      (ret_pc)
   );

   assign detect = is_fault(kind);

   illx_ctx #(
      .AW          (AW),
      .SRW         (SRW),
      .VEC_W       (VEC_W),
      .VEC_GEN     (VEC_GEN),
      .VEC_SLOT    (VEC_SLOT),
      .CAPTURE_VBR (CAPTURE_VBR)
   ) u_ctx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .capture_i  (capture),
      .kind_i     (kind),
      .ret_pc_i   (ret_pc),
      .sr_i       (sr_i),
      .sp_i       (sp_i),
      .vbr_i      (vbr_i),
      .addr_sr_o  (addr_sr),
      .data_sr_o  (data_sr),
      .addr_pc_o  (addr_pc),
      .data_pc_o  (data_pc),
      .vec_addr_o (vec_addr),
      .sp_final_o (sp_final)
   );

   illx_fsm #(
      .AW (AW)
   ) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .detect_i       (detect),
      .busy_o         (busy_o),
      .capture_o      (capture),
      .addr_sr_i      (addr_sr),
      .data_sr_i      (data_sr),
      .addr_pc_i      (addr_pc),
      .data_pc_i      (data_pc),
      .vec_addr_i     (vec_addr),
      .sp_final_i     (sp_final),
      .mem_wr_en_o    (mem_wr_en_o),
      .mem_wr_addr_o  (mem_wr_addr_o),
      .mem_wr_data_o  (mem_wr_data_o),
      .mem_wr_ready_i (mem_wr_ready_i),
      .mem_rd_en_o    (mem_rd_en_o),
      .mem_rd_addr_o  (mem_rd_addr_o),
      .mem_rd_data_i  (mem_rd_data_i),
      .mem_rd_ready_i (mem_rd_ready_i),
      .pc_load_o      (pc_load_o),
      .pc_new_o       (pc_new_o),
      .sp_load_o      (sp_load_o),
      .sp_new_o       (sp_new_o)
   );

   // R4
   idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !detect) |=> !busy_o);

   // R9
   busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && detect) |=> busy_o);

   // R8
   sp_with_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc_load_o |-> sp_load_o);

endmodule

// File: tb/illx_entry_seq_tb.sv
module illx_entry_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dv = 1'b0, du = 1'b0, dpw = 1'b0, dsl = 1'b0;
   logic [31:0] dpc = '0, dtgt = '0, sr = '0, sp = '0, vbr = '0;
   logic        busy, wr_en, rd_en, pc_load, sp_load, wr_rdy, rd_rdy;
   logic [31:0] wr_addr, wr_data, rd_addr, rd_data, pc_new, sp_new;

   int checks = 0;
   int fails  = 0;
   int lat    = 0;
   int cnt    = 0;
   logic log_clr = 1'b0;

   logic [31:0] w_addr [0:7];
   logic [31:0] w_data [0:7];
   int w_n = 0, r_n = 0, pl_n = 0, busy_n = 0, gap_n = 0;
   logic [31:0] r_addr, last_pc, last_sp;
   logic        last_spl;

   always #2 clk = ~clk;

   illx_entry_seq u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .dec_valid_i(dv), .dec_undef_i(du), .dec_pc_write_i(dpw), .dec_in_slot_i(dsl),
      .dec_pc_i(dpc), .slot_target_i(dtgt), .sr_i(sr), .sp_i(sp), .vbr_i(vbr),
      .busy_o(busy),
      .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data), .mem_wr_ready_i(wr_rdy),
      .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data), .mem_rd_ready_i(rd_rdy),
      .pc_load_o(pc_load), .pc_new_o(pc_new), .sp_load_o(sp_load), .sp_new_o(sp_new)
   );

   // memory model: ready after lat wait cycles, read data derived from address
   assign wr_rdy  = wr_en && (cnt == lat);
   assign rd_rdy  = rd_en && (cnt == lat);
   assign rd_data = rd_addr ^ 32'hC0DE_0000;

   always @(posedge clk) begin
      if (!rst_n) cnt <= 0;
      else if ((wr_en || rd_en) && !(wr_rdy || rd_rdy)) cnt <= cnt + 1;
      else cnt <= 0;
   end

   always @(posedge clk) begin
      if (log_clr) begin
         w_n <= 0; r_n <= 0; pl_n <= 0; busy_n <= 0; gap_n <= 0;
      end else if (rst_n) begin
         if (wr_en && wr_rdy && w_n < 8) begin
            w_addr[w_n] <= wr_addr; w_data[w_n] <= wr_data; w_n <= w_n + 1;
         end
         if (rd_en && rd_rdy) begin r_addr <= rd_addr; r_n <= r_n + 1; end
         if (pc_load) begin
            last_pc <= pc_new; last_sp <= sp_new; last_spl <= sp_load; pl_n <= pl_n + 1;
         end
         if (busy) busy_n <= busy_n + 1;
         if (pl_n == 1 && !busy && !pc_load) gap_n <= gap_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   task automatic wait_loads(input int n);
      int t = 0;
      while (pl_n < n && t < 200) begin @(negedge clk); t++; end
      if (t >= 200) chk(1'b0, "WD", "sequence timeout", 32'(pl_n), 32'(n));
   endtask

   // one full sequence: drive a detection for one cycle and check every access
   task automatic run_fault(input string req, input bit slot, input bit undef, input bit pcw,
                            input logic [31:0] pc, input logic [31:0] tgt,
                            input logic [31:0] srv, input logic [31:0] spv,
                            input logic [31:0] vb, input int l,
                            input logic [31:0] exp_ret, input int vec);
      logic [31:0] va;
      lat = l;
      clear_logs();
      dv = 1'b1; dsl = slot; du = undef; dpw = pcw;
      dpc = pc; dtgt = tgt; sr = srv; sp = spv; vbr = vb;
      @(negedge clk);
      chk(busy == 1'b1, "R9", "busy after detect", 32'(busy), 32'd1);
      dv = 1'b0; du = 1'b0; dpw = 1'b0; dsl = 1'b0;
      sp = 32'hDEAD_0000; vbr = 32'hBAD0_0000;
      wait_loads(1);
      @(negedge clk);
      va = vb + 32'(4 * vec);
      chk(w_n == 2, req, "write count", 32'(w_n), 32'd2);
      chk(w_addr[0] == spv - 4 && w_data[0] == srv, "R5", "SR push", w_addr[0], spv - 4);
      chk(w_addr[1] == spv - 8, "R5", "PC push address", w_addr[1], spv - 8);
      chk(w_data[1] == exp_ret, req, "stacked return", w_data[1], exp_ret);
      chk(r_n == 1 && r_addr == va, "R6", "vector address", r_addr, va);
      chk(last_pc == (va ^ 32'hC0DE_0000), "R8", "handler load", last_pc, va ^ 32'hC0DE_0000);
      chk(last_spl && last_sp == spv - 8, "R8", "sp update", last_sp, spv - 8);
      chk(busy_n == 3 * (l + 1) + 1, "R7", "busy length", 32'(busy_n), 32'(3 * (l + 1) + 1));
      chk(busy == 1'b0, "R9", "busy released", 32'(busy), 32'd0);
   endtask

   // R4: inputs that must start nothing
   task automatic run_quiet(input bit v, input bit slot, input bit undef, input bit pcw);
      int seen = 0;
      clear_logs();
      dv = v; dsl = slot; du = undef; dpw = pcw; dpc = 32'h0000_4000;
      repeat (6) begin @(negedge clk); if (busy) seen++; end
      dv = 1'b0; du = 1'b0; dpw = 1'b0; dsl = 1'b0;
      repeat (2) @(negedge clk);
      chk(seen == 0 && w_n == 0 && r_n == 0 && pl_n == 0, "R4", "no sequence",
          32'(seen + w_n + r_n + pl_n), 32'd0);
   endtask

   // R9: a second fault while busy is ignored
   task automatic run_ignore();
      lat = 1;
      clear_logs();
      dv = 1'b1; du = 1'b1; dsl = 1'b0; dpc = 32'h0000_1230;
      sr = 32'h0000_00F0; sp = 32'h0000_8000; vbr = 32'h0001_0000;
      @(negedge clk);
      dv = 1'b0; du = 1'b0;
      @(negedge clk);
      dv = 1'b1; du = 1'b1; dsl = 1'b1; dtgt = 32'h0000_7770; dpc = 32'h0000_9990;
      sp = 32'h0000_6000;
      @(negedge clk);
      dv = 1'b0; du = 1'b0; dsl = 1'b0;
      wait_loads(1);
      repeat (10) @(negedge clk);
      chk(pl_n == 1 && w_n == 2, "R9", "single sequence", 32'(pl_n), 32'd1);
      chk(w_data[1] == 32'h0000_1230, "R9", "first context kept", w_data[1], 32'h0000_1230);
      chk(r_addr == 32'h0001_0010, "R9", "first vector kept", r_addr, 32'h0001_0010);
   endtask

   // R9: load cycle and a fresh detection coincide
   task automatic run_back_to_back();
      lat = 0;
      clear_logs();
      dv = 1'b1; du = 1'b1; dsl = 1'b0; dpc = 32'h0000_2220;
      sr = 32'h0000_0003; sp = 32'h0000_A000; vbr = 32'h0000_0400;
      wait_loads(2);
      dv = 1'b0; du = 1'b0;
      repeat (4) @(negedge clk);
      chk(pl_n == 2 && w_n == 4, "R9", "two sequences", 32'(pl_n), 32'd2);
      chk(gap_n == 1, "R9", "one idle cycle between", 32'(gap_n), 32'd1);
      chk(w_data[3] == 32'h0000_2220 && w_addr[2] == 32'h0000_9FFC, "R9", "second context",
          w_data[3], 32'h0000_2220);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10
      chk(!busy && !wr_en && !rd_en && !pc_load && !sp_load, "R10", "reset outputs",
          {27'd0, busy, wr_en, rd_en, pc_load, sp_load}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R3 general fault
      run_fault("R3", 1'b0, 1'b1, 1'b0, 32'h0000_1004, 32'h0000_5550,
                32'h0000_01F3, 32'h0000_F000, 32'h0002_0000, 0, 32'h0000_1004, 4);
      // R1 undefined in slot, with ready latency
      run_fault("R1", 1'b1, 1'b1, 1'b0, 32'h0000_2002, 32'h0000_3300,
                32'h8000_0001, 32'h0000_E010, 32'h0003_0100, 2, 32'h0000_3300, 6);
      // R2 defined PC-writer in slot
      run_fault("R2", 1'b1, 1'b0, 1'b1, 32'h0000_2006, 32'h0000_4400,
                32'h0000_0000, 32'h0000_D000, 32'h0000_0000, 1, 32'h0000_4400, 6);
      // R7 long stall
      run_fault("R7", 1'b0, 1'b1, 1'b1, 32'h0000_0A0A, 32'h0000_0B0B,
                32'h0000_7777, 32'h0001_0000, 32'h0000_0800, 3, 32'h0000_0A0A, 4);
      run_quiet(1'b1, 1'b0, 1'b0, 1'b1);
      run_quiet(1'b0, 1'b1, 1'b1, 1'b1);
      run_quiet(1'b1, 1'b0, 1'b0, 1'b0);
      run_ignore();
      run_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule